// File: doc/BRIEF.md
# Multi-Domain Clock Stop Controller

This block sits between the clock sources and the clock outputs of a clock generator. It passes three clock groups through gates: a processor group, a memory group that runs at processor speed from its own source, and a bus group that runs from a slower source at half or two-fifths of the processor rate. Two active-low requests, which may change at any time, stop the groups. The processor-stop request parks both the processor group and the memory group. The bus-stop request parks only the bus group.

Each request is brought into every domain it controls through a chain of flip-flops clocked by that domain's own source. The result is copied into a gate enable on the falling edge of that source. Because of this, a gated output only ever stops or starts while its source is low. Every high phase it shows is complete, and a parked output rests low. An active-low power-down input clears every enable at once and holds all outputs low, whatever the stop requests say. Each group has a status flag that is high while its gate is open.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While rst_n is low, every gated output and every status flag is low.
- R2: With both stop requests and pwr_dn_n high, every bit of each output group equals its source clock, and all bits of a group are identical.
- R3: With cpu_stop_n low, the processor and memory groups stop and their flags drop, while the bus group keeps toggling and bus_run stays high.
- R4: With bus_stop_n low, only the bus group stops and bus_run drops; the processor and memory groups keep toggling.
- R5: A stopped output is held at logic 0 through both phases of its source clock.
- R6: Every high phase on a gated output lasts the full high phase of its source, and a gate opens or closes only while its source is low (power-down excepted).
- R7: A processor-stop change, held steady, is taken in by SYNC_STAGES rising edges of the processor (memory) source, and the gate of that domain changes at the very next falling edge: within one domain cycle of the synchronized request, never earlier.
- R8: A bus-stop change follows the same rule on the bus source, so the gate changes within one bus cycle (two processor cycles, fewer than four) of the synchronized request, never before the second bus rising edge.
- R9: pwr_dn_n low forces every output and flag low within the same time step, even in the middle of a high phase and with both stop requests high. After it is released, no output rises before SYNC_STAGES rising edges of its own source have passed.
- R10: Each status flag (cpu_run, mem_run, bus_run) is high exactly while its group passes clock; once the inputs have settled, it equals stop request AND pwr_dn_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor source clock |
| mem_clk | input | 1 | Memory source clock, processor rate |
| bus_clk | input | 1 | Bus source clock, slower rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_stop_n | input | 1 | Asynchronous stop request for processor and memory groups, active low |
| bus_stop_n | input | 1 | Asynchronous stop request for the bus group, active low |
| pwr_dn_n | input | 1 | Power-down, active low, overrides all |
| cpu_clk_out | output | N_CPU | Gated processor clocks |
| mem_clk_out | output | N_MEM | Gated memory clocks |
| bus_clk_out | output | N_BUS | Gated bus clocks |
| cpu_run | output | 1 | Processor group running |
| mem_run | output | 1 | Memory group running |
| bus_run | output | 1 | Bus group running |

## Verification
The bench changes the requests half a cycle away from the edges. It then checks that the flag does not move after the second rising edge and does move at the following falling edge. A design with one synchronizer stage too few or too many fails there. Pulse-width monitors on every group catch a gate that opens or closes on the wrong edge, which shows up as a runt high pulse. Power-down is asserted and released in the middle of a high phase to catch a design that lets an output start at once instead of waiting for the synchronizer. A design that wires the wrong request to the memory or bus group shows up when one group stays stopped while another is expected to keep running.

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl #(
  parameter int N_CPU       = 4,
  parameter int N_MEM       = 6,
  parameter int N_BUS       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             cpu_clk,
  input  logic             mem_clk,
  input  logic             bus_clk,
  input  logic             rst_n,
  input  logic             cpu_stop_n,
  input  logic             bus_stop_n,
  input  logic             pwr_dn_n,
  output logic [N_CPU-1:0] cpu_clk_out,
  output logic [N_MEM-1:0] mem_clk_out,
  output logic [N_BUS-1:0] bus_clk_out,
  output logic             cpu_run,
  output logic             mem_run,
  output logic             bus_run
);
  localparam int ND = 3;

  logic [ND-1:0] src, req_n, en;
  logic          clr_n;

  assign clr_n = rst_n & pwr_dn_n;
  assign src   = {bus_clk, mem_clk, cpu_clk};
  assign req_n = {bus_stop_n, cpu_stop_n, cpu_stop_n};

  for (genvar d = 0; d < ND; d++) begin : g_dom
    logic [SYNC_STAGES-1:0] sync;
    logic                   gate_q;

    always_ff @(posedge src[d] or negedge clr_n)
      if (!clr_n) sync <= '0;
      else        sync <= {sync[SYNC_STAGES-2:0], req_n[d]};

    always_ff @(negedge src[d] or negedge clr_n)
      if (!clr_n) gate_q <= 1'b0;
      else        gate_q <= sync[SYNC_STAGES-1];

    assign en[d] = gate_q;
  end

  assign cpu_clk_out = {N_CPU{cpu_clk & en[0]}};
  assign mem_clk_out = {N_MEM{mem_clk & en[1]}};
  assign bus_clk_out = {N_BUS{bus_clk & en[2]}};
  assign cpu_run     = en[0];
  assign mem_run     = en[1];
  assign bus_run     = en[2];
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
`timescale 1ns/1ps
module clk_stop_ctrl_chk (
  input logic cpu_clk,
  input logic mem_clk,
  input logic bus_clk,
  input logic rst_n,
  input logic cpu_stop_n,
  input logic bus_stop_n,
  input logic pwr_dn_n,
  input logic cpu_run,
  input logic mem_run,
  input logic bus_run
);
  logic [2:0] cc, mc, bc;

  always_ff @(posedge cpu_clk or negedge rst_n)
    if (!rst_n) cc <= '0; else if (cc != 3'd7) cc <= cc + 3'd1;
  always_ff @(posedge mem_clk or negedge rst_n)
    if (!rst_n) mc <= '0; else if (mc != 3'd7) mc <= mc + 3'd1;
  always_ff @(posedge bus_clk or negedge rst_n)
    if (!rst_n) bc <= '0; else if (bc != 3'd7) bc <= bc + 3'd1;

  a_r3_cpu_stops: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    (cc >= 3'd4 && !cpu_stop_n && !$past(cpu_stop_n) && !$past(cpu_stop_n, 2) && !$past(cpu_stop_n, 3))
    |-> !cpu_run);

  a_r3_mem_stops: assert property (@(posedge mem_clk) disable iff (!rst_n)
    (mc >= 3'd4 && !cpu_stop_n && !$past(cpu_stop_n) && !$past(cpu_stop_n, 2) && !$past(cpu_stop_n, 3))
    |-> !mem_run);

  a_r4_bus_stops: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (bc >= 3'd4 && !bus_stop_n && !$past(bus_stop_n) && !$past(bus_stop_n, 2) && !$past(bus_stop_n, 3))
    |-> !bus_run);

  a_r7_cpu_restarts: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    (cc >= 3'd4 && cpu_stop_n && $past(cpu_stop_n) && $past(cpu_stop_n, 2) && $past(cpu_stop_n, 3) &&
     pwr_dn_n && $past(pwr_dn_n) && $past(pwr_dn_n, 2) && $past(pwr_dn_n, 3))
    |-> cpu_run);

  a_r8_bus_restarts: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (bc >= 3'd4 && bus_stop_n && $past(bus_stop_n) && $past(bus_stop_n, 2) && $past(bus_stop_n, 3) &&
     pwr_dn_n && $past(pwr_dn_n) && $past(pwr_dn_n, 2) && $past(pwr_dn_n, 3))
    |-> bus_run);

  a_r9_pd_clears: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    !pwr_dn_n |-> (!cpu_run && !mem_run && !bus_run));

  always @(cpu_run)
    if (rst_n && pwr_dn_n) a_r6_cpu_low_phase: assert (cpu_clk == 1'b0);
  always @(mem_run)
    if (rst_n && pwr_dn_n) a_r6_mem_low_phase: assert (mem_clk == 1'b0);
  always @(bus_run)
    if (rst_n && pwr_dn_n) a_r6_bus_low_phase: assert (bus_clk == 1'b0);
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk u_chk (
  .cpu_clk(cpu_clk), .mem_clk(mem_clk), .bus_clk(bus_clk), .rst_n(rst_n),
  .cpu_stop_n(cpu_stop_n), .bus_stop_n(bus_stop_n), .pwr_dn_n(pwr_dn_n),
  .cpu_run(cpu_run), .mem_run(mem_run), .bus_run(bus_run)
);

// File: tb/clk_stop_ctrl_test.sv
`timescale 1ns/1ps
module clk_stop_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_CPU = 4;
  localparam int N_MEM = 6;
  localparam int N_BUS = 7;

  logic cpu_clk = 1'b0, mem_clk = 1'b0, bus_clk = 1'b0;
  logic rst_n = 1'b0, cpu_stop_n = 1'b1, bus_stop_n = 1'b1, pwr_dn_n = 1'b1;
  logic [N_CPU-1:0] cpu_clk_out;
  logic [N_MEM-1:0] mem_clk_out;
  logic [N_BUS-1:0] bus_clk_out;
  logic cpu_run, mem_run, bus_run;

  int n_chk = 0, n_fail = 0;
  int runt_cpu = 0, runt_mem = 0, runt_bus = 0;
  int puls_cpu = 0, puls_mem = 0, puls_bus = 0;
  time rise_cpu = 0, rise_mem = 0, rise_bus = 0;
  bit done = 1'b0;

  clk_stop_ctrl #(.N_CPU(N_CPU), .N_MEM(N_MEM), .N_BUS(N_BUS), .SYNC_STAGES(2)) uut (
    .cpu_clk(cpu_clk), .mem_clk(mem_clk), .bus_clk(bus_clk), .rst_n(rst_n),
    .cpu_stop_n(cpu_stop_n), .bus_stop_n(bus_stop_n), .pwr_dn_n(pwr_dn_n),
    .cpu_clk_out(cpu_clk_out), .mem_clk_out(mem_clk_out), .bus_clk_out(bus_clk_out),
    .cpu_run(cpu_run), .mem_run(mem_run), .bus_run(bus_run));

  always #(CLK_PERIOD/2) cpu_clk = ~cpu_clk;
  initial begin #3; forever #(CLK_PERIOD/2) mem_clk = ~mem_clk; end
  always @(posedge cpu_clk) bus_clk <= ~bus_clk;

  // R6 pulse-width monitors
  always @(posedge cpu_clk_out[0]) rise_cpu = $time;
  always @(negedge cpu_clk_out[0]) if (pwr_dn_n && rst_n) begin
    puls_cpu++; if ($time - rise_cpu != CLK_PERIOD/2) runt_cpu++; end
  always @(posedge mem_clk_out[0]) rise_mem = $time;
  always @(negedge mem_clk_out[0]) if (pwr_dn_n && rst_n) begin
    puls_mem++; if ($time - rise_mem != CLK_PERIOD/2) runt_mem++; end
  always @(posedge bus_clk_out[0]) rise_bus = $time;
  always @(negedge bus_clk_out[0]) if (pwr_dn_n && rst_n) begin
    puls_bus++; if ($time - rise_bus != CLK_PERIOD) runt_bus++; end

  function automatic logic exp_run(input logic req_n, input logic pd_n);
    return req_n & pd_n;
  endfunction

  function automatic logic [31:0] grp(input logic v, input int n);
    return v ? ((32'h1 << n) - 32'h1) : 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic chk_follow(input string req, input logic ec, input logic em, input logic eb);
    @(posedge cpu_clk); #1;
    chk({req, " cpu high phase"}, 32'(cpu_clk_out), grp(ec, N_CPU));
    @(posedge mem_clk); #1;
    chk({req, " mem high phase"}, 32'(mem_clk_out), grp(em, N_MEM));
    @(posedge bus_clk); #1;
    chk({req, " bus high phase"}, 32'(bus_clk_out), grp(eb, N_BUS));
    @(negedge cpu_clk); #1;
    chk("R5 cpu low phase", 32'(cpu_clk_out), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));

    // R1 reset
    repeat (4) @(posedge cpu_clk);
    #1;
    chk("R1 outputs in reset", {cpu_clk_out, mem_clk_out, bus_clk_out} != 0, 32'h0);
    chk("R1 flags in reset", {cpu_run, mem_run, bus_run}, 32'h0);
    rst_n = 1'b1;
    repeat (8) @(posedge cpu_clk);
    #1;
    chk("R10 flags running", {cpu_run, mem_run, bus_run}, 32'h7);
    chk_follow("R2", 1'b1, 1'b1, 1'b1);

    // R7 processor stop latency, R3 memory follows, bus unaffected
    @(negedge cpu_clk); #1; cpu_stop_n = 1'b0;
    @(posedge cpu_clk); #1;
    @(posedge cpu_clk); #1;
    chk("R7 cpu not early", 32'(cpu_run), 32'h1);
    @(negedge cpu_clk); #1;
    chk("R7 cpu stops at next fall", 32'(cpu_run), 32'h0);
    repeat (4) @(posedge cpu_clk);
    #1;
    chk("R3 mem stopped", 32'(mem_run), 32'h0);
    chk("R3 bus still running", 32'(bus_run), 32'h1);
    chk_follow("R3", 1'b0, 1'b0, 1'b1);
    @(negedge cpu_clk); #1; cpu_stop_n = 1'b1;
    @(posedge cpu_clk); #1;
    @(posedge cpu_clk); #1;
    chk("R7 cpu restart not early", 32'(cpu_run), 32'h0);
    @(negedge cpu_clk); #1;
    chk("R7 cpu restarts at next fall", 32'(cpu_run), 32'h1);
    repeat (4) @(posedge cpu_clk);

    // R8 bus stop latency, R4 processor and memory unaffected
    @(negedge bus_clk); #1; bus_stop_n = 1'b0;
    @(posedge bus_clk); #1;
    @(posedge bus_clk); #1;
    chk("R8 bus not early", 32'(bus_run), 32'h1);
    @(negedge bus_clk); #1;
    chk("R8 bus stops within one bus cycle", 32'(bus_run), 32'h0);
    repeat (4) @(posedge cpu_clk);
    #1;
    chk("R4 cpu and mem running", {cpu_run, mem_run}, 32'h3);
    chk_follow("R4", 1'b1, 1'b1, 1'b0);
    @(negedge bus_clk); #1; bus_stop_n = 1'b1;
    @(posedge bus_clk); #1;
    @(posedge bus_clk); #1;
    chk("R8 bus restart not early", 32'(bus_run), 32'h0);
    @(negedge bus_clk); #1;
    chk("R8 bus restarts", 32'(bus_run), 32'h1);
    repeat (4) @(posedge cpu_clk);

    // R9 power-down mid high phase
    @(posedge cpu_clk); #2; pwr_dn_n = 1'b0;
    #1;
    chk("R9 outputs forced low", {cpu_clk_out, mem_clk_out, bus_clk_out} != 0, 32'h0);
    chk("R9 flags forced low", {cpu_run, mem_run, bus_run}, 32'h0);
    repeat (10) @(posedge cpu_clk);
    #1;
    chk("R9 held low with stops high", {cpu_clk_out, mem_clk_out, bus_clk_out} != 0, 32'h0);
    @(posedge cpu_clk); #2; pwr_dn_n = 1'b1;
    #1;
    chk("R9 no start on release", 32'(cpu_clk_out), 32'h0);
    @(posedge cpu_clk); #1;
    chk("R9 no start after one edge", 32'(cpu_clk_out), 32'h0);
    repeat (12) @(posedge cpu_clk);
    #1;
    chk("R9 running after release", {cpu_run, mem_run, bus_run}, 32'h7);

    // constrained random mix
    for (int i = 0; i < 60; i++) begin
      logic cs, bs, pd;
      int r, d;
      cs = ($urandom % 4) != 0;
      bs = ($urandom % 4) != 0;
      pd = ($urandom % 8) != 0;
      r = $urandom % 4;
      d = (r == 0) ? 1 : (r == 1) ? 2 : (r == 2) ? 4 : 6;
      @(posedge cpu_clk); #(d);
      cpu_stop_n = cs; bus_stop_n = bs; pwr_dn_n = pd;
      repeat (12) @(posedge cpu_clk);
      #1;
      chk("R10 cpu_run", 32'(cpu_run), 32'(exp_run(cs, pd)));
      chk("R10 mem_run", 32'(mem_run), 32'(exp_run(cs, pd)));
      chk("R10 bus_run", 32'(bus_run), 32'(exp_run(bs, pd)));
      chk_follow("R2 random", exp_run(cs, pd), exp_run(cs, pd), exp_run(bs, pd));
    end
    @(posedge cpu_clk); #1;
    cpu_stop_n = 1'b1; bus_stop_n = 1'b1; pwr_dn_n = 1'b1;
    repeat (12) @(posedge cpu_clk);

    chk("R6 cpu runt pulses", 32'(runt_cpu), 32'h0);
    chk("R6 mem runt pulses", 32'(runt_mem), 32'h0);
    chk("R6 bus runt pulses", 32'(runt_bus), 32'h0);
    chk("R6 pulses seen", 32'(puls_cpu > 0 && puls_mem > 0 && puls_bus > 0), 32'h1);
    summary();
  end
endmodule